// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits between an SDRAM command sequencer and the column address pins of a memory array model or controller back end. When a read or write command starts, it captures an 8-bit start column. From the next clock on, it issues one internal column address per clock until the burst is complete. The burst length and the address ordering come from a mode word, which the block holds in its own register and decodes. The same decode supplies the CAS latency in clocks and an error flag for illegal settings.

Two address orders are available. A sequential burst counts upward from the start column and wraps modulo 256. An interleaved burst keeps the upper column bits fixed and XORs the low bits of the start column with the beat number. A full-page burst is sequential only and runs until a terminate strobe stops it. A new command may cut a running burst short and start over from a new column.

The address stream has no back-pressure input. Once a burst has started, the block issues one address every clock, and the consumer must take the address in every cycle that `col_valid` is high. The only ways to stop the stream are the terminate strobe and the start of another command.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and on the first clock after it, `col_valid` and `col_last` are 0, `cas_clocks` is 2 and `mode_err` is 0. The reset mode word is CAS code 010, sequential, one-word bursts.
- R2: On a `mode_load` clock the block stores `mode_word[6:0]`. From the next clock, CAS code bits [6:4] give `cas_clocks`: 010 gives 2 and 011 gives 3. Every other CAS code gives 0 and sets `mode_err`.
- R3: Length code bits [2:0] select the burst length: 000 is 1 word, 001 is 2, 010 is 4 and 011 is 8. Code 111 is full page, which is legal only when bit [3] is 0. Any other length code, or full page with bit [3] set to 1, sets `mode_err`.
- R4: A `cmd_start` with `mode_err` low makes `col_valid` go to 1 on the next clock, with `col_out` equal to `start_col`.
- R5: When bit [3] is 0 (sequential order), beat m of the burst presents (n+m) mod 256, where n is the start column.
- R6: When bit [3] is 1 (interleaved order) and the burst length is L, beat m presents the bits of n above log2(L) unchanged, with its low log2(L) bits XORed with m.
- R7: `col_last` is 1 on exactly the final beat of a fixed-length burst. `col_valid` is 0 on the clock after that beat unless a new command starts.
- R8: A full-page burst continues past n+255 back to n and never asserts `col_last`.
- R9: A `burst_stop` clock without `cmd_start` makes `col_valid` 0 on the next clock. When both are high on the same clock, the new command wins.
- R10: A `cmd_start` during a running burst restarts the burst at beat 0 with the new start column.
- R11: A `cmd_start` while `mode_err` is 1 is ignored: an idle block stays idle, and a running burst continues unchanged.
- R12: The burst length and order are captured at `cmd_start`. A `mode_load` during a burst changes neither the order nor the length of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_load | input | 1 | Stores mode_word into the mode register |
| mode_word | input | MODE_W | Address-bus value for the mode register; bits [6:0] are used |
| cmd_start | input | 1 | Read or write command start strobe |
| start_col | input | COL_W | Start column for the command |
| burst_stop | input | 1 | Burst terminate strobe |
| col_out | output | COL_W | Current internal column address |
| col_valid | output | 1 | col_out carries a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_clocks | output | 2 | Decoded CAS latency in clocks; 0 when reserved |
| mode_err | output | 1 | Mode word holds a reserved or illegal setting |

## Verification
A corrupted beat counter or captured start column shows up on `col_out` in the very cycle it goes wrong. The reason is that the address is formed from those registers without any further pipelining. A wrong captured length or order usually appears within one or two beats, either as a misplaced `col_last` or as a bad interleave pattern. The exception is a lost full-page flag, which surfaces only as an early stop, up to 256 beats later. For that reason the long full-page run is compared on every beat through the wrap. A stale mode decode appears on `cas_clocks` and `mode_err` one clock after the load.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic         full;
    burst_order_e order;
    logic [1:0]   len_log2;
  } burst_cfg_t;

  localparam logic [6:0] MODE_RESET = 7'b010_0_000;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  output burst_cfg_t        cfg,
  output logic [1:0]        cas_clocks,
  output logic              mode_err
);

  logic [6:0] mreg_q;
  logic [2:0] cl_code;
  logic [2:0] len_code;
  logic       cl_bad;
  logic       len_bad;

  always_ff @(posedge clk) begin
    if (rst)            mreg_q <= MODE_RESET;
    else if (mode_load) mreg_q <= mode_word[6:0];
  end

  assign cl_code  = mreg_q[6:4];
  assign len_code = mreg_q[2:0];

  always_comb begin
    cas_clocks = 2'd0;
    cl_bad     = 1'b1;
    case (cl_code)
      3'b010: begin cas_clocks = 2'd2; cl_bad = 1'b0; end
      3'b011: begin cas_clocks = 2'd3; cl_bad = 1'b0; end
      default: ;
    endcase
  end

  always_comb begin
    cfg.order    = burst_order_e'(mreg_q[3]);
    cfg.full     = 1'b0;
    cfg.len_log2 = len_code[1:0];
    len_bad      = 1'b0;
    case (len_code)
      3'b000, 3'b001, 3'b010, 3'b011: ;
      3'b111: begin
        cfg.full     = 1'b1;
        cfg.len_log2 = 2'd0;
        len_bad      = mreg_q[3];
      end
      default: len_bad = 1'b1;
    endcase
  end

  assign mode_err = cl_bad | len_bad;

  p_cas_legal_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_err |-> (cas_clocks == 2'd2 || cas_clocks == 2'd3));

  p_load_takes_r2: assert property (@(posedge clk) disable iff (rst)
    mode_load && mode_word[6:4] == 3'b011 |=> cas_clocks == 2'd3);

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic             cfg_ok,
  input  burst_cfg_t       cfg,
  input  logic [COL_W-1:0] start_col,
  input  logic             burst_stop,
  output logic             active_q,
  output logic [COL_W-1:0] start_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output logic             ilv_q,
  output logic             last
);

  logic             take;
  logic [COL_W-1:0] new_mask;

  assign take = cmd_start & cfg_ok;

  always_comb begin
    new_mask = '0;
    if (cfg.full) new_mask = '1;
    else          new_mask = COL_W'((1 << cfg.len_log2) - 1);
  end

  assign last = active_q & ~full_q & (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      start_q  <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (take) begin
      active_q <= 1'b1;
      start_q  <= start_col;
      beat_q   <= '0;
      mask_q   <= new_mask;
      full_q   <= cfg.full;
      ilv_q    <= (cfg.order == ORD_ILV);
    end else if (active_q) begin
      if (burst_stop || last) active_q <= 1'b0;
      else                    beat_q   <= beat_q + 1'b1;
    end
  end

  p_restart_beat0_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> active_q && beat_q == '0);

  p_err_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_start && !cfg_ok && !active_q |=> !active_q);

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_q,
  input  logic [COL_W-1:0] beat_q,
  input  logic [COL_W-1:0] mask_q,
  input  logic             ilv_q,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign seq_col = start_q + beat_q;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign ilv_col[b] = mask_q[b] ? (start_q[b] ^ beat_q[b]) : start_q[b];
  end

  assign col = ilv_q ? ilv_col : seq_col;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              burst_stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              col_last,
  output logic [1:0]        cas_clocks,
  output logic              mode_err
);

  burst_cfg_t       cfg;
  logic             active_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic             last;

  colgen_mode_dec #(.MODE_W(MODE_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .mode_load  (mode_load),
    .mode_word  (mode_word),
    .cfg        (cfg),
    .cas_clocks (cas_clocks),
    .mode_err   (mode_err)
  );

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cfg_ok     (!mode_err),
    .cfg        (cfg),
    .start_col  (start_col),
    .burst_stop (burst_stop),
    .active_q   (active_q),
    .start_q    (start_q),
    .beat_q     (beat_q),
    .mask_q     (mask_q),
    .full_q     (full_q),
    .ilv_q      (ilv_q),
    .last       (last)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .start_q (start_q),
    .beat_q  (beat_q),
    .mask_q  (mask_q),
    .ilv_q   (ilv_q),
    .col     (col_out)
  );

  assign col_valid = active_q;
  assign col_last  = last;

  p_first_beat_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_start && !mode_err |=> col_valid && col_out == $past(start_col));

  p_seq_step_r5: assert property (@(posedge clk) disable iff (rst)
    col_valid && !ilv_q && $past(col_valid) && !$past(cmd_start)
    |-> col_out == COL_W'($past(col_out) + 1'b1));

  p_last_ends_r7: assert property (@(posedge clk) disable iff (rst)
    col_last && !cmd_start |=> !col_valid);

  p_full_runs_r8: assert property (@(posedge clk) disable iff (rst)
    col_valid && full_q && !burst_stop |=> col_valid && !col_last);

  p_stop_r9: assert property (@(posedge clk) disable iff (rst)
    burst_stop && !cmd_start |=> !col_valid);

endmodule

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_load = 1'b0;
  logic [11:0] mode_word = '0;
  logic        cmd_start = 1'b0;
  logic [7:0]  start_col = '0;
  logic        burst_stop = 1'b0;
  logic [7:0]  col_out;
  logic        col_valid;
  logic        col_last;
  logic [1:0]  cas_clocks;
  logic        mode_err;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  sdram_burst_colgen u0 (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .cmd_start(cmd_start), .start_col(start_col), .burst_stop(burst_stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
    .cas_clocks(cas_clocks), .mode_err(mode_err)
  );

  // reference model
  int m_word = 'h20;
  int m_act = 0, m_start = 0, m_beat = 0, m_len = 1, m_full = 0, m_ilv = 0;

  function automatic int mdl_cas(int w);
    int c = (w >> 4) & 7;
    if (c == 2) return 2;
    if (c == 3) return 3;
    return 0;
  endfunction

  function automatic int mdl_err(int w);
    int bl = w & 7;
    int bt = (w >> 3) & 1;
    if (mdl_cas(w) == 0) return 1;
    if (bl <= 3) return 0;
    if (bl == 7 && bt == 0) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_word = 'h20; m_act = 0; m_beat = 0;
    end else begin
      if (cmd_start && mdl_err(m_word) == 0) begin
        m_act = 1; m_start = start_col; m_beat = 0;
        m_full = ((m_word & 7) == 7);
        m_len = m_full ? 256 : (1 << (m_word & 7));
        m_ilv = (m_word >> 3) & 1;
      end else if (m_act) begin
        if (burst_stop || (!m_full && m_beat == m_len - 1)) m_act = 0;
        else m_beat = (m_beat + 1) % 256;
      end
      if (mode_load) m_word = mode_word & 'h7f;
    end
  end

  function automatic int mdl_col();
    if (m_ilv) return (m_start / m_len) * m_len + ((m_start % m_len) ^ m_beat);
    return (m_start + m_beat) % 256;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("valid", col_valid, m_act);
      chk("cas", cas_clocks, mdl_cas(m_word));
      chk("err", mode_err, mdl_err(m_word));
      if (m_act) begin
        chk("col", col_out, mdl_col());
        chk("last", col_last, (!m_full && m_beat == m_len - 1) ? 1 : 0);
      end else chk("last", col_last, 0);
    end
  end

  task automatic load(int w);
    @(negedge clk); mode_load = 1'b1; mode_word = 12'(w);
    @(negedge clk); mode_load = 1'b0;
  endtask

  task automatic start(int c);
    @(negedge clk); cmd_start = 1'b1; start_col = 8'(c);
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", col_valid, 0);
    chk("R1 last in reset", col_last, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 cas after reset", cas_clocks, 2);
    chk("R1 err after reset", mode_err, 0);
    // R4 single word burst
    cur_req = "R4"; start('h5a); idle(3);
    // R2 cas codes
    cur_req = "R2"; load('h30); idle(1); chk("R2 cas3", cas_clocks, 3);
    load('h40); idle(1); chk("R2 reserved err", mode_err, 1);
    // R11 start under error
    cur_req = "R11"; start('h11); idle(2); chk("R11 idle", col_valid, 0);
    // R3 length codes
    cur_req = "R3"; load('h24); idle(1); chk("R3 bl100 err", mode_err, 1);
    load('h2f); idle(1); chk("R3 full+ilv err", mode_err, 1);
    load('h27); idle(1); chk("R3 full seq ok", mode_err, 0);
    // R5 sequential wrap
    cur_req = "R5"; load('h23); start('hfc); idle(10);
    load('h22); start('h3e); idle(6);
    // R6 interleave
    cur_req = "R6"; load('h2a); start('h35); idle(6);
    load('h2b); start('hfe); idle(10);
    load('h39); start('h07); idle(4);
    // R7 last on 2-word burst
    cur_req = "R7"; load('h21); start('h80); idle(3);
    // R8 full page through wrap
    cur_req = "R8"; load('h27); start('h10); idle(262);
    // R9 stop
    cur_req = "R9"; @(negedge clk); burst_stop = 1'b1; @(negedge clk); burst_stop = 1'b0;
    idle(2); chk("R9 stopped", col_valid, 0);
    load('h23); start('h40); idle(2);
    @(negedge clk); cmd_start = 1'b1; burst_stop = 1'b1; start_col = 8'h90;
    @(negedge clk); cmd_start = 1'b0; burst_stop = 1'b0;
    chk("R9 start wins", col_out, 'h90); idle(9);
    // R10 restart mid burst
    cur_req = "R10"; start('h20); idle(3); start('hc4); idle(10);
    // R11 error start during burst
    cur_req = "R11"; start('h60); idle(1); load('h50); start('h01); idle(8);
    // R12 load mid-burst
    cur_req = "R12"; load('h23); start('h0d); idle(1); load('h29); idle(8);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule